// File: doc/BRIEF.md
# Interleaved Four-Lane Bidirectional Column Shifter

This block loads a row of 2-bit column codes for a dot-matrix driver. Four 2-bit serial lanes, named A, B, C and D, feed one chain of 320 columns. On every qualified shift, each lane delivers one symbol, and the four symbols land in four neighbouring columns at the entry end of the chain. Everything already stored moves four columns further along. Each lane therefore covers every fourth column, and the four lanes together fill the row in 80 shifts.

A direction input selects which end of the row is the entry end. When direction is high, new symbols enter at column 1 and travel toward column 320. When direction is low, the whole mapping is mirrored. The block runs on a single design clock. A shift-enable strobe marks each qualified shift clock edge, and an active-low chip select must also be asserted for a shift to happen. The complete 640-bit row is presented in parallel on the output, ready for a downstream latch.

Top module: `colshift_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets every column to code 00, so `frame_o` reads all zeros after that edge.
- R2: Lane packing on `lanes_i` is A in bits [1:0], B in [3:2], C in [5:4] and D in [7:6]. Column k (1 to 320) appears on `frame_o` bits [2k-1:2k-2].
- R3: With `dir` high, a qualified shift puts the symbols of lanes A, B, C and D into columns 1, 2, 3 and 4.
- R4: With `dir` high, a qualified shift moves the content of column k into column k+4. A group entered on one shift occupies columns 317 to 320 after 79 further forward shifts (80 shifts counting its own entry).
- R5: With `dir` low, a qualified shift puts the symbols of lanes A, B, C and D into columns 320, 319, 318 and 317.
- R6: With `dir` low, a qualified shift moves the content of column k into column k-4. A group entered on one shift reaches columns 4 down to 1 after 80 shifts.
- R7: While `cs_n` is high, a clock edge with `shift_en` high leaves every column unchanged.
- R8: While `shift_en` is low, every column holds its value whatever `dir` and `lanes_i` do.
- R9: `dir` is sampled at each qualified shift. Changing it moves no stored data, and the next shift uses the new mapping.
- R10: The effect of a qualified shift appears on `frame_o` right after the rising edge at which `shift_en` and `cs_n` were sampled. There is no extra pipeline stage.
- R11: Data shifted past the far end of the chain is lost. In forward mode the old content of columns 317 to 320 is gone after the next shift, and in reverse mode the old content of columns 1 to 4 is gone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Strobe marking one qualified shift clock edge |
| cs_n | input | 1 | Chip select, active low; shifting is allowed only while low |
| dir | input | 1 | 1: entry at column 1; 0: entry at column 320 |
| lanes_i | input | 8 | Lane symbols: A [1:0], B [3:2], C [5:4], D [7:6] |
| frame_o | output | 640 | Whole row; column k on bits [2k-1:2k-2] |

## Verification
Every result of this block is due one clock after its stimulus: a shift, a hold or a reset sampled at a rising edge shows on `frame_o` directly after that same edge. The driver applies inputs at the falling edge and pushes the expected row for the next rising edge. The monitor pops that row one nanosecond after the edge and compares all 640 bits, so each comparison lands within the cycle its result belongs to. Long forward and reverse runs of 80 or more shifts exercise the 317 to 320 and 1 to 4 end positions, and the loss of data past the far end.

// File: rtl/colshift_pkg.sv
package colshift_pkg;

    // width of one column code
    localparam int SYM_W = 2;

    typedef logic [SYM_W-1:0] sym_t;

endpackage

// File: rtl/colshift_feed.sv
module colshift_feed
    import colshift_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   shift_en,
    input  logic                   cs_n,
    input  logic [LANES*SYM_W-1:0] lanes_i,
    output logic                   shift_o,
    output sym_t                   slot_o [LANES]
);

    // slot j is the symbol placed j columns in from the active entry end
    for (genvar j = 0; j < LANES; j++) begin : g_slot
        assign slot_o[j] = lanes_i[j*SYM_W +: SYM_W];
    end

    // a shift counts only when the strobe fires with the chip selected
    assign shift_o = shift_en & ~cs_n;

endmodule

// File: rtl/colshift_store.sv
module colshift_store
    import colshift_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LANE_DEPTH = 80,
    localparam int COLS      = LANES * LANE_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_i,
    input  logic dir,
    input  sym_t slot_i [LANES],
    output sym_t col_o  [COLS]
);

    typedef struct {
        sym_t col [COLS];
    } row_t;

    row_t row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (rst) begin
            for (int c = 0; c < COLS; c++) begin
                row_d.col[c] = '0;
            end
        end else if (shift_i) begin
            if (dir) begin
                // forward: travel toward the high column numbers
                for (int c = 0; c < COLS - LANES; c++) begin
                    row_d.col[c + LANES] = row_q.col[c];
                end
                for (int j = 0; j < LANES; j++) begin
                    row_d.col[j] = slot_i[j];
                end
            end else begin
                // reverse: travel toward column 1
                for (int c = 0; c < COLS - LANES; c++) begin
                    row_d.col[c] = row_q.col[c + LANES];
                end
                for (int j = 0; j < LANES; j++) begin
                    row_d.col[COLS-1-j] = slot_i[j];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        row_q <= row_d;
    end

    assign col_o = row_q.col;

endmodule

// File: rtl/colshift_pack.sv
module colshift_pack
    import colshift_pkg::*;
#(
    parameter int COLS = 320,
    localparam int FW  = COLS * SYM_W
) (
    input  sym_t            col_i [COLS],
    output logic [FW-1:0]   frame_o
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign frame_o[c*SYM_W +: SYM_W] = col_i[c];
    end

endmodule

// File: rtl/colshift_top.sv
module colshift_top
    import colshift_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LANE_DEPTH = 80,
    localparam int COLS      = LANES * LANE_DEPTH,
    localparam int FW        = COLS * SYM_W,
    localparam int LW        = LANES * SYM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          cs_n,
    input  logic          dir,
    input  logic [LW-1:0] lanes_i,
    output logic [FW-1:0] frame_o
);

    logic shift_w;
    sym_t slot_w [LANES];
    sym_t col_w  [COLS];

    colshift_feed #(.LANES(LANES)) u_feed (
        .shift_en (shift_en),
        .cs_n     (cs_n),
        .lanes_i  (lanes_i),
        .shift_o  (shift_w),
        .slot_o   (slot_w)
    );

    colshift_store #(.LANES(LANES), .LANE_DEPTH(LANE_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift_w),
        .dir     (dir),
        .slot_i  (slot_w),
        .col_o   (col_w)
    );

    colshift_pack #(.COLS(COLS)) u_pack (
        .col_i   (col_w),
        .frame_o (frame_o)
    );

endmodule

// File: rtl/colshift_chk.sv
module colshift_chk
    import colshift_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LANE_DEPTH = 80,
    localparam int COLS      = LANES * LANE_DEPTH,
    localparam int FW        = COLS * SYM_W,
    localparam int LW        = LANES * SYM_W
) (
    input logic          clk,
    input logic          rst,
    input logic          shift_en,
    input logic          cs_n,
    input logic          dir,
    input logic [LW-1:0] lanes_i,
    input logic [FW-1:0] frame_o
);

    // lanes in mirrored slot order for the reverse entry window
    logic [LW-1:0] lanes_rev;
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            lanes_rev[(LANES-1-j)*SYM_W +: SYM_W] = lanes_i[j*SYM_W +: SYM_W];
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> frame_o == '0);

    assert_fwd_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !cs_n && dir) |=> frame_o[LW-1:0] == $past(lanes_i));

    assert_fwd_move_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !cs_n && dir) |=> frame_o[FW-1:LW] == $past(frame_o[FW-LW-1:0]));

    assert_rev_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !cs_n && !dir) |=> frame_o[FW-1 -: LW] == $past(lanes_rev));

    assert_rev_move_R6: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !cs_n && !dir) |=> frame_o[FW-LW-1:0] == $past(frame_o[FW-1:LW]));

    assert_cs_hold_R7: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(frame_o));

    assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(frame_o));

endmodule

bind colshift_top colshift_chk #(.LANES(LANES), .LANE_DEPTH(LANE_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .cs_n     (cs_n),
    .dir      (dir),
    .lanes_i  (lanes_i),
    .frame_o  (frame_o)
);

// File: tb/sim_colshift_top.sv
module sim_colshift_top;

    localparam int LANES = 4;
    localparam int DEPTH = 80;
    localparam int COLS  = LANES * DEPTH;
    localparam int FW    = COLS * 2;
    localparam int LW    = LANES * 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shift_en = 1'b0;
    logic          cs_n = 1'b1;
    logic          dir = 1'b1;
    logic [LW-1:0] lanes_i = '0;
    logic [FW-1:0] frame_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [1:0]    mdl [COLS];
    logic [FW-1:0] exp_q [$];
    string         tag_q [$];

    always #2 clk = ~clk;

    colshift_top #(.LANES(LANES), .LANE_DEPTH(DEPTH)) u0 (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .cs_n     (cs_n),
        .dir      (dir),
        .lanes_i  (lanes_i),
        .frame_o  (frame_o)
    );

    function automatic logic [FW-1:0] mdl_frame();
        logic [FW-1:0] f;
        for (int c = 0; c < COLS; c++) f[c*2 +: 2] = mdl[c];
        return f;
    endfunction

    // driver: apply one cycle of stimulus, update the model, queue the expected row
    task automatic step(input bit r, input bit en, input bit cs, input bit d,
                        input logic [LW-1:0] ln, input string tag);
        @(negedge clk);
        rst = r; shift_en = en; cs_n = cs; dir = d; lanes_i = ln;
        if (r) begin
            for (int c = 0; c < COLS; c++) mdl[c] = 2'b00;
        end else if (en && !cs) begin
            if (d) begin
                for (int c = COLS - 1; c >= LANES; c--) mdl[c] = mdl[c-LANES];
                for (int j = 0; j < LANES; j++) mdl[j] = ln[j*2 +: 2];
            end else begin
                for (int c = 0; c < COLS - LANES; c++) mdl[c] = mdl[c+LANES];
                for (int j = 0; j < LANES; j++) mdl[COLS-1-j] = ln[j*2 +: 2];
            end
        end
        exp_q.push_back(mdl_frame());
        tag_q.push_back(tag);
    endtask

    // monitor: one result due right after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [FW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (frame_o !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual=%h expected=%h", t, frame_o, e);
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] first_grp;

        // R1: reset clears the row
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 8'hFF, "R1 reset");

        // R2 R3 R10: forward entry with distinct patterns, visible one clock later
        step(0, 1, 0, 1, 8'hE4, "R3 fwd entry A=0 B=1 C=2 D=3");
        step(0, 1, 0, 1, 8'h1B, "R2 lane packing reversed pattern");
        step(0, 1, 0, 1, 8'hAA, "R10 one-clock result");
        step(0, 1, 0, 1, 8'h55, "R3 fwd entry 55");

        // R8: strobe low, inputs moving
        for (int i = 0; i < 4; i++) step(0, 0, 0, i[0], 8'(i * 61 + 7), "R8 hold en low");
        // R7: chip deselected
        for (int i = 0; i < 4; i++) step(0, 1, 1, i[0], 8'(i * 45 + 9), "R7 hold cs high");

        // R4: one tagged group travels to columns 317..320
        step(1, 0, 1, 1, 8'h00, "R1 reset again");
        first_grp = 8'hC6;
        step(0, 1, 0, 1, first_grp, "R4 first group");
        for (int i = 1; i < DEPTH; i++) step(0, 1, 0, 1, 8'(i * 37 + 11), "R4 fwd run");
        // R11: the group falls off the far end
        step(0, 1, 0, 1, 8'h39, "R11 fwd drop");

        // R5 R6: reverse from clear
        step(1, 0, 1, 0, 8'h00, "R1 reset before reverse");
        step(0, 1, 0, 0, 8'hE4, "R5 rev entry A=0 B=1 C=2 D=3");
        for (int i = 1; i < DEPTH; i++) step(0, 1, 0, 0, 8'(i * 53 + 2), "R6 rev run");
        step(0, 1, 0, 0, 8'h72, "R11 rev drop");
        step(0, 1, 0, 0, 8'h8D, "R6 rev after drop");

        // R9: direction flips between shifts
        step(0, 0, 0, 1, 8'hFF, "R9 dir change alone");
        step(0, 1, 0, 1, 8'h3C, "R9 fwd after flip");
        step(0, 1, 0, 0, 8'hC3, "R9 rev after flip");
        step(0, 1, 0, 1, 8'h96, "R9 fwd again");
        step(0, 1, 1, 0, 8'h11, "R7 deselected with flip");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule